// File: doc/BRIEF.md
# Prefixed Instruction Element-Loop Sequencer

This block sits behind instruction fetch and pre-decode. It accepts a 64-bit fetched pair, a 32-bit prefix word followed by a 32-bit suffix word. It sorts the pair into one of the prefix encoding areas and handles it in one of three ways:

- It raises an illegal-instruction trap for reserved areas and for suffixes that cannot be vectorised.
- It issues the suffix once, unchanged.
- It expands the suffix into a stream of element operations, with an element offset added to the register numbers.

Two loop modes exist, selected by a prefix bit. In horizontal-first mode, every element of one instruction is issued, one per cycle, before the next instruction is taken. In vertical-first mode, each prefixed instruction issues a single element at a persistent element offset. That offset is shared by all following prefixed instructions and moves forward only on an explicit step strobe. It wraps to zero at the vector length, and a done pulse marks the wrap. Suffix class and an unvectoriseable flag come from an external pre-decode stage.

Bit positions follow big-endian instruction numbering: prefix bit k of the pair is `in_prefix[31-k]`, and pair bit 32 is `in_suffix[31]`.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `op_valid`, `trap` and `done` are 0, and the vertical-first offset is 0.
- R2: A pair traps in each of these cases: `in_prefix[31:26]` is not 9; `in_prefix[25]`=0 with `in_suffix[31]`=0; `in_prefix[25]`=1 with `in_prefix[24]`=0 and `in_prefix[23:0]`=0; `in_prefix[24]`=0 with `in_prefix[23:0]` non-zero.
- R3: A trap is a one-cycle `trap` pulse in the cycle after acceptance. No element op is issued, and `in_ready` is 1 in that same cycle.
- R4: `in_prefix[25:24]`=00 with `in_prefix[23:0]`=0 and `in_suffix[31]`=1 is a scalar: one op with `op_elem`=0 and `op_last`=1. `op_rt`, `op_ra` and `op_rb` are `in_suffix[25:21]`, `[20:16]` and `[15:11]`, zero-extended to 7 bits. This holds even when `in_unvec`=1.
- R5: `in_prefix[24]`=1 with `in_prefix[23:0]`=0 is identity: exactly one op with offset 0, whatever the vector length.
- R6: `in_prefix[24]`=1 with `in_unvec`=1 traps, both in the identity form and in the looping form.
- R7: In horizontal-first mode (`in_prefix[24]`=1, `in_prefix[2]`=0, field non-zero), N ops are issued with `op_elem` running 0..N-1. `op_last` is set only on the final op, and `in_ready` stays 0 until that op is taken.
- R8: Each register is a 7-bit value made of 2 extension bits and the 5-bit suffix field. The extension bits are `in_prefix[4:3]` for RT, `[6:5]` for RA and `[8:7]` for RB. `in_prefix[0]` adds the element offset to RT, and `in_prefix[1]` adds it to RA and RB. The sum wraps modulo 128.
- R9: In vertical-first mode (`in_prefix[2]`=1), each instruction issues one op with `op_last`=1 at the stored offset. Consecutive instructions reuse that offset.
- R10: A `step_cmd` pulse advances the stored offset by one. When the new value would reach N, the offset becomes 0 and `done` pulses for one cycle in the next cycle.
- R11: `done` pulses for one cycle in the cycle after the final horizontal-first op is taken. Horizontal-first runs and traps leave the stored vertical-first offset unchanged.
- R12: While `op_valid`=1 and `op_ready`=0, the op outputs hold steady.
- R13: N is `vec_len`, except that `vec_len`=0 gives N=1 and values above 64 give N=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction pair offered |
| in_ready | output | 1 | Sequencer can take a pair |
| in_prefix | input | 32 | Prefix word |
| in_suffix | input | 32 | Suffix word |
| in_class | input | 2 | Pre-decoded suffix class |
| in_unvec | input | 1 | Pre-decode marks suffix unvectoriseable |
| vec_len | input | 7 | Vector length |
| step_cmd | input | 1 | Advance the vertical-first offset |
| op_valid | output | 1 | Element op present |
| op_ready | input | 1 | Consumer takes the element op |
| op_suffix | output | 32 | Suffix word of the op |
| op_class | output | 2 | Suffix class of the op |
| op_rt | output | 7 | Offset destination register |
| op_ra | output | 7 | Offset first source register |
| op_rb | output | 7 | Offset second source register |
| op_elem | output | 6 | Element offset of the op |
| op_last | output | 1 | Final op of the instruction |
| trap | output | 1 | Illegal-instruction trap pulse |
| done | output | 1 | Loop completion or offset wrap pulse |

## Verification
A wrong element counter shows at the ports on the very next op, as a wrong `op_elem` and shifted register numbers. It also moves the point where `op_last` and `done` appear. A corrupted stored vertical-first offset stays hidden until the next vertical-first instruction issues, or until a step reaches the wrap. For that reason, the offset is probed through a vertical-first issue right after every trap, horizontal run and step. A misclassified area shows one cycle after acceptance, either as a trap pulse where an op was due or as an op where a trap was due.

// File: rtl/elseq_pkg.sv
package elseq_pkg;
    localparam int MAXVL      = 64;
    localparam int EW         = $clog2(MAXVL);
    localparam int VLW        = $clog2(MAXVL + 1);
    localparam int RW         = 7;
    localparam int XW         = 2;
    localparam int FW         = 5;
    localparam logic [5:0] PO_PREFIX = 6'd9;

    typedef enum logic [1:0] {K_TRAP, K_ONCE, K_HLOOP, K_VSTEP} kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             dmark;
        logic             smark;
        logic [XW-1:0]    ext_t;
        logic [XW-1:0]    ext_a;
        logic [XW-1:0]    ext_b;
    } dec_t;

    typedef struct packed {
        logic [31:0]      suffix;
        logic [1:0]       cls;
        logic [RW-1:0]    bt;
        logic [RW-1:0]    ba;
        logic [RW-1:0]    bb;
        logic             dmark;
        logic             smark;
        logic             loop;
    } held_t;

    function automatic logic [VLW-1:0] clamp_vl(input logic [VLW-1:0] v);
        if (v == '0)
            return VLW'(1);
        else if (v > VLW'(MAXVL))
            return VLW'(MAXVL);
        else
            return v;
    endfunction
endpackage

// File: rtl/elseq_decode.sv
module elseq_decode
    import elseq_pkg::*;
(
    input  logic [31:0] prefix,
    input  logic [31:0] suffix,
    input  logic        unvec,
    output dec_t        dec
);
    logic        po_ok;
    logic        space_sel;
    logic        vec_mark;
    logic        dw_top;
    logic [23:0] fld;

    assign po_ok     = (prefix[31:26] == PO_PREFIX);
    assign space_sel = prefix[25];
    assign vec_mark  = prefix[24];
    assign fld       = prefix[23:0];
    assign dw_top    = suffix[31];

    always_comb begin
        dec      = '0;
        dec.kind = K_TRAP;
        if (!po_ok) begin
            dec.kind = K_TRAP;
        end else if (!space_sel && !dw_top) begin
            dec.kind = K_TRAP;
        end else if (!vec_mark) begin
            if (fld != '0 || space_sel)
                dec.kind = K_TRAP;
            else
                dec.kind = K_ONCE;
        end else if (unvec) begin
            dec.kind = K_TRAP;
        end else if (fld == '0) begin
            dec.kind = K_ONCE;
        end else begin
            dec.kind  = fld[2] ? K_VSTEP : K_HLOOP;
            dec.dmark = fld[0];
            dec.smark = fld[1];
            dec.ext_t = fld[4:3];
            dec.ext_a = fld[6:5];
            dec.ext_b = fld[8:7];
        end
    end
endmodule

// File: rtl/elseq_regoff.sv
module elseq_regoff #(
    parameter int RW     = 7,
    parameter int EW     = 6,
    parameter int NREG   = 3
) (
    input  logic [NREG-1:0][RW-1:0] base,
    input  logic [NREG-1:0]         mark,
    input  logic [EW-1:0]           off,
    output logic [NREG-1:0][RW-1:0] regs
);
    localparam int SW = (RW > EW) ? RW : EW;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [SW-1:0] sum;
        assign sum     = SW'(base[g]) + SW'(off);
        assign regs[g] = mark[g] ? sum[RW-1:0] : base[g];
    end
endmodule

// File: rtl/elseq_ctrl.sv
module elseq_ctrl
    import elseq_pkg::*;
#(
    parameter int P_EW  = EW,
    parameter int P_VLW = VLW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  dec_t             dec,
    input  logic [31:0]      suffix,
    input  logic [1:0]       cls,
    input  logic [P_VLW-1:0] nel,
    input  logic             step_cmd,
    input  logic             op_ready,
    output logic             op_valid,
    output held_t            held,
    output logic [P_EW-1:0]  cnt,
    output logic             op_last,
    output logic             trap,
    output logic             done
);
    logic             busy;
    logic [P_VLW-1:0] nel_q;
    logic [P_EW-1:0]  vf_off;
    logic             accept;
    logic             take;
    logic             step_wrap;

    assign in_ready  = !busy;
    assign op_valid  = busy;
    assign accept    = in_valid && in_ready;
    assign take      = busy && op_ready;
    assign op_last   = !held.loop || (P_VLW'(cnt) == nel_q - P_VLW'(1));
    assign step_wrap = (P_VLW'(vf_off) + P_VLW'(1)) >= nel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            held   <= '0;
            cnt    <= '0;
            nel_q  <= P_VLW'(1);
            vf_off <= '0;
            trap   <= 1'b0;
            done   <= 1'b0;
        end else begin
            trap <= 1'b0;
            done <= 1'b0;
            if (accept) begin
                if (dec.kind == K_TRAP) begin
                    trap <= 1'b1;
                end else begin
                    busy         <= 1'b1;
                    held.suffix  <= suffix;
                    held.cls     <= cls;
                    held.bt      <= {dec.ext_t, suffix[25:21]};
                    held.ba      <= {dec.ext_a, suffix[20:16]};
                    held.bb      <= {dec.ext_b, suffix[15:11]};
                    held.dmark   <= dec.dmark;
                    held.smark   <= dec.smark;
                    held.loop    <= (dec.kind == K_HLOOP);
                    cnt          <= (dec.kind == K_VSTEP) ? vf_off : '0;
                    nel_q        <= nel;
                end
            end
            if (take) begin
                if (op_last) begin
                    busy <= 1'b0;
                    if (held.loop)
                        done <= 1'b1;
                end else begin
                    cnt <= cnt + P_EW'(1);
                end
            end
            if (step_cmd) begin
                if (step_wrap) begin
                    vf_off <= '0;
                    done   <= 1'b1;
                end else begin
                    vf_off <= vf_off + P_EW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [31:0]    in_prefix,
    input  logic [31:0]    in_suffix,
    input  logic [1:0]     in_class,
    input  logic           in_unvec,
    input  logic [VLW-1:0] vec_len,
    input  logic           step_cmd,
    output logic           op_valid,
    input  logic           op_ready,
    output logic [31:0]    op_suffix,
    output logic [1:0]     op_class,
    output logic [RW-1:0]  op_rt,
    output logic [RW-1:0]  op_ra,
    output logic [RW-1:0]  op_rb,
    output logic [EW-1:0]  op_elem,
    output logic           op_last,
    output logic           trap,
    output logic           done
);
    dec_t                dec;
    held_t               held;
    logic [EW-1:0]       cnt;
    logic [VLW-1:0]      nel;
    logic [2:0][RW-1:0]  base;
    logic [2:0]          mark;
    logic [2:0][RW-1:0]  regs;

    assign nel = clamp_vl(vec_len);

    elseq_decode u_dec (
        .prefix (in_prefix),
        .suffix (in_suffix),
        .unvec  (in_unvec),
        .dec    (dec)
    );

    elseq_ctrl #(.P_EW(EW), .P_VLW(VLW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .dec      (dec),
        .suffix   (in_suffix),
        .cls      (in_class),
        .nel      (nel),
        .step_cmd (step_cmd),
        .op_ready (op_ready),
        .op_valid (op_valid),
        .held     (held),
        .cnt      (cnt),
        .op_last  (op_last),
        .trap     (trap),
        .done     (done)
    );

    assign base = {held.bb, held.ba, held.bt};
    assign mark = {held.smark, held.smark, held.dmark};

    elseq_regoff #(.RW(RW), .EW(EW), .NREG(3)) u_off (
        .base (base),
        .mark (mark),
        .off  (cnt),
        .regs (regs)
    );

    assign op_rt     = regs[0];
    assign op_ra     = regs[1];
    assign op_rb     = regs[2];
    assign op_elem   = cnt;
    assign op_suffix = held.suffix;
    assign op_class  = held.cls;
endmodule

// File: rtl/elseq_chk.sv
module elseq_chk
    import elseq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          op_valid,
    input logic          op_ready,
    input logic [RW-1:0] op_rt,
    input logic [RW-1:0] op_ra,
    input logic [RW-1:0] op_rb,
    input logic [EW-1:0] op_elem,
    input logic          op_last,
    input logic          trap
);
    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        trap |-> !op_valid); // R3
    AST_TRAP_READY: assert property (@(posedge clk) disable iff (rst)
        trap |-> in_ready); // R3
    AST_ISSUE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> !in_ready); // R7
    AST_ELEM_SEQ: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && !op_last) |=> (op_valid && op_elem == EW'($past(op_elem) + EW'(1)))); // R7
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_elem) && $stable(op_rt)
                                     && $stable(op_ra) && $stable(op_rb) && $stable(op_last))); // R12
endmodule

bind elem_loop_seq elseq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_rt    (op_rt),
    .op_ra    (op_ra),
    .op_rb    (op_rb),
    .op_elem  (op_elem),
    .op_last  (op_last),
    .trap     (trap)
);

// File: tb/elem_loop_seq_test.sv
module elem_loop_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_prefix;
    logic [31:0] in_suffix;
    logic [1:0]  in_class;
    logic        in_unvec;
    logic [6:0]  vec_len;
    logic        step_cmd;
    logic        op_valid;
    logic        op_ready;
    logic [31:0] op_suffix;
    logic [1:0]  op_class;
    logic [6:0]  op_rt;
    logic [6:0]  op_ra;
    logic [6:0]  op_rb;
    logic [5:0]  op_elem;
    logic        op_last;
    logic        trap;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    elem_loop_seq uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_prefix(in_prefix), .in_suffix(in_suffix), .in_class(in_class),
        .in_unvec(in_unvec), .vec_len(vec_len), .step_cmd(step_cmd),
        .op_valid(op_valid), .op_ready(op_ready), .op_suffix(op_suffix),
        .op_class(op_class), .op_rt(op_rt), .op_ra(op_ra), .op_rb(op_rb),
        .op_elem(op_elem), .op_last(op_last), .trap(trap), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    function automatic logic [31:0] mkpre(input bit b6, input bit b7, input logic [23:0] f);
        return {6'd9, b6, b7, f};
    endfunction

    function automatic logic [23:0] mkfld(input bit dm, input bit sm, input bit vf,
                                         input logic [1:0] et, input logic [1:0] ea,
                                         input logic [1:0] eb);
        return {15'd0, eb, ea, et, vf, sm, dm};
    endfunction

    function automatic logic [31:0] mksuf(input bit b32, input logic [4:0] t,
                                         input logic [4:0] a, input logic [4:0] b);
        return {b32, 5'd0, t, a, b, 11'd0};
    endfunction

    function automatic int expreg(input logic [1:0] ext, input logic [4:0] f5,
                                  input int off, input bit mark);
        int v;
        v = int'({ext, f5});
        return mark ? ((v + off) % 128) : v;
    endfunction

    // Drive one pair and verify the trap or the whole op stream it produces.
    task automatic exec(input logic [31:0] pre, input logic [31:0] suf, input bit unvec,
                        input bit exp_trap, input int exp_n, input int exp_start,
                        input bit exp_done, input string tag);
        int n;
        bit dm, sm;
        n  = 0;
        dm = pre[0];
        sm = pre[1];
        @(negedge clk);
        in_prefix = pre;
        in_suffix = suf;
        in_unvec  = unvec;
        in_class  = 2'd2;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(trap == exp_trap, {tag, " trap"}, trap, exp_trap);
        chk(in_ready == exp_trap, {tag, " ready after accept"}, in_ready, exp_trap);
        if (exp_trap) begin
            chk(op_valid == 1'b0, {tag, " no op on trap"}, op_valid, 0);
            @(negedge clk);
            chk(trap == 1'b0, {tag, " trap one cycle"}, trap, 0);
        end else begin
            for (int i = 0; i < 80; i++) begin
                if (op_valid) begin
                    chk(op_elem == exp_start + n, {tag, " elem"}, op_elem, exp_start + n);
                    chk(op_rt == expreg(pre[4:3], suf[25:21], exp_start + n, dm), {tag, " rt"},
                        op_rt, expreg(pre[4:3], suf[25:21], exp_start + n, dm));
                    chk(op_ra == expreg(pre[6:5], suf[20:16], exp_start + n, sm), {tag, " ra"},
                        op_ra, expreg(pre[6:5], suf[20:16], exp_start + n, sm));
                    chk(op_rb == expreg(pre[8:7], suf[15:11], exp_start + n, sm), {tag, " rb"},
                        op_rb, expreg(pre[8:7], suf[15:11], exp_start + n, sm));
                    chk(op_suffix == suf && op_class == 2'd2, {tag, " suffix/class"}, op_suffix, suf);
                    n++;
                    chk(op_last == (n == exp_n), {tag, " last flag"}, op_last, (n == exp_n));
                    if (op_last) begin
                        @(negedge clk);
                        chk(done == exp_done, {tag, " done"}, done, exp_done);
                        break;
                    end
                end
                @(negedge clk);
            end
            chk(n == exp_n, {tag, " op count"}, n, exp_n);
        end
    endtask

    task automatic do_step(input bit exp_done, input string tag);
        @(negedge clk);
        step_cmd = 1'b1;
        @(negedge clk);
        step_cmd = 1'b0;
        chk(done == exp_done, {tag, " step done"}, done, exp_done);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(op_valid == 1'b0, "R1 op_valid", op_valid, 0);
        chk(trap == 1'b0 && done == 1'b0, "R1 trap/done", {trap, done}, 0);
        vec_len = 7'd5;
        exec(mkpre(1, 1, mkfld(1, 1, 1, 0, 0, 0)), mksuf(0, 1, 2, 3), 0, 0, 1, 0, 0, "R1 offset zero");
    endtask

    task automatic t_traps();
        vec_len = 7'd4;
        exec({6'd1, 26'h100_0001}, mksuf(1, 1, 1, 1), 0, 1, 0, 0, 0, "R2 not prefix");
        exec(mkpre(0, 1, mkfld(1, 1, 0, 0, 0, 0)), mksuf(0, 1, 1, 1), 0, 1, 0, 0, 0, "R2 low space bit32 zero");
        exec(mkpre(1, 0, 24'd0), mksuf(1, 1, 1, 1), 0, 1, 0, 0, 0, "R2 reserved 32-bit");
        exec(mkpre(1, 0, 24'h10), mksuf(1, 1, 1, 1), 0, 1, 0, 0, 0, "R2 single form high");
        exec(mkpre(0, 0, 24'h1), mksuf(1, 1, 1, 1), 0, 1, 0, 0, 0, "R3 single form low");
    endtask

    task automatic t_scalar();
        vec_len = 7'd8;
        exec(mkpre(0, 0, 24'd0), mksuf(1, 3, 4, 5), 0, 0, 1, 0, 0, "R4 scalar");
        exec(mkpre(0, 0, 24'd0), mksuf(1, 9, 17, 30), 1, 0, 1, 0, 0, "R6 scalar unvec issues");
    endtask

    task automatic t_identity();
        vec_len = 7'd8;
        exec(mkpre(1, 1, 24'd0), mksuf(0, 6, 7, 8), 0, 0, 1, 0, 0, "R5 identity high");
        exec(mkpre(0, 1, 24'd0), mksuf(1, 6, 7, 8), 0, 0, 1, 0, 0, "R5 identity low");
        exec(mkpre(1, 1, 24'd0), mksuf(0, 6, 7, 8), 1, 1, 0, 0, 0, "R6 identity unvec");
        exec(mkpre(1, 1, mkfld(1, 1, 0, 0, 0, 0)), mksuf(0, 6, 7, 8), 1, 1, 0, 0, 0, "R6 loop unvec");
    endtask

    task automatic t_hloop();
        vec_len = 7'd4;
        exec(mkpre(1, 1, mkfld(1, 1, 0, 1, 0, 2)), mksuf(0, 10, 20, 31), 0, 0, 4, 0, 1, "R7 hf both");
        vec_len = 7'd3;
        exec(mkpre(1, 1, mkfld(1, 0, 0, 3, 1, 0)), mksuf(0, 31, 2, 4), 0, 0, 3, 0, 1, "R8 dest wrap");
        exec(mkpre(1, 1, mkfld(0, 1, 0, 2, 3, 3)), mksuf(0, 5, 31, 30), 0, 0, 3, 0, 1, "R8 src only");
    endtask

    task automatic t_vstep();
        logic [31:0] vpre;
        vpre = mkpre(1, 1, mkfld(1, 1, 1, 0, 1, 0));
        vec_len = 7'd3;
        exec(vpre, mksuf(0, 2, 3, 4), 0, 0, 1, 0, 0, "R9 vf first");
        exec(vpre, mksuf(0, 12, 13, 14), 0, 0, 1, 0, 0, "R9 vf reuse");
        do_step(0, "R10 step to 1");
        exec(vpre, mksuf(0, 2, 3, 4), 0, 0, 1, 1, 0, "R9 vf at 1");
        exec(mkpre(1, 0, 24'd0), mksuf(1, 1, 1, 1), 0, 1, 0, 0, 0, "R11 trap in vf");
        exec(vpre, mksuf(0, 2, 3, 4), 0, 0, 1, 1, 0, "R11 offset after trap");
        exec(mkpre(1, 1, mkfld(1, 1, 0, 0, 0, 0)), mksuf(0, 1, 1, 1), 0, 0, 3, 0, 1, "R11 hf between");
        exec(vpre, mksuf(0, 2, 3, 4), 0, 0, 1, 1, 0, "R11 offset after hf");
        do_step(0, "R10 step to 2");
        do_step(1, "R10 step wraps");
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        exec(vpre, mksuf(0, 2, 3, 4), 0, 0, 1, 0, 0, "R10 vf after wrap");
    endtask

    task automatic t_backpressure();
        vec_len  = 7'd2;
        op_ready = 1'b0;
        @(negedge clk);
        in_prefix = mkpre(1, 1, mkfld(1, 1, 0, 0, 0, 0));
        in_suffix = mksuf(0, 8, 9, 10);
        in_unvec  = 1'b0;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(op_valid == 1'b1 && op_elem == 6'd0, "R12 held elem", op_elem, 0);
            chk(op_rt == 7'd8, "R12 held rt", op_rt, 8);
            @(negedge clk);
        end
        op_ready = 1'b1;
        @(negedge clk);
        chk(op_valid && op_elem == 6'd1 && op_last, "R12 next after release", op_elem, 1);
        chk(op_rt == 7'd9, "R12 rt after release", op_rt, 9);
        @(negedge clk);
        chk(done == 1'b1 && op_valid == 1'b0, "R12 done after release", done, 1);
    endtask

    task automatic t_clamp();
        vec_len = 7'd0;
        exec(mkpre(1, 1, mkfld(1, 1, 0, 0, 0, 0)), mksuf(0, 1, 2, 3), 0, 0, 1, 0, 1, "R13 zero length");
        vec_len = 7'd100;
        exec(mkpre(1, 1, mkfld(1, 0, 0, 0, 0, 0)), mksuf(0, 0, 2, 3), 0, 0, 64, 0, 1, "R13 clamp 64");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_prefix = '0;
        in_suffix = '0;
        in_class  = '0;
        in_unvec  = 1'b0;
        vec_len   = 7'd4;
        step_cmd  = 1'b0;
        op_ready  = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_traps();
        t_scalar();
        t_identity();
        t_hloop();
        t_vstep();
        t_backpressure();
        t_clamp();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule